// File: doc/BRIEF.md
# Sixteen-Function Arithmetic/Logic Unit Slice

The block combines two W-bit operands under a 4-bit function code, a mode bit and a carry input. With the mode bit high, it applies one of sixteen bitwise two-input functions. With the mode bit low, it forms one of sixteen arithmetic results. Each arithmetic result is an (W+1)-bit sum of two operand-derived terms plus the carry input, and the carry-out is the top bit of that sum. A flag reports an all-ones result. Under the code that forms A + ~B + carry, that flag marks operand equality when the carry input is 0.

The operands enter through a valid/ready stream. Each accepted request produces one registered response, together with the carry-out and the flag, on an output stream. Input and output follow the usual rule: a beat moves on any rising edge where valid and ready are both high. The output register holds its value while the consumer stalls. The input side is ready when the register is empty, or when the consumer takes the held beat in the same cycle. So a stalled consumer pushes back on the producer, and without any stall the slice accepts one request per cycle. Function code, mode and carry travel with the operands as part of the same request beat.

Top module: `alu16_slice`

## Requirements
- R1: With in_mode=1, out_f is the bitwise function of A and B given by in_sel: 0 NOT A, 1 NOT(A AND B), 2 (NOT A) OR B, 3 all ones, 4 NOT(A OR B), 5 NOT B, 6 NOT(A XOR B), 7 A OR NOT B, 8 (NOT A) AND B, 9 A XOR B, 10 B, 11 A OR B, 12 all zeros, 13 A AND NOT B, 14 A AND B, 15 A.
- R2: With in_mode=1, in_cin has no effect on out_f, and out_cout is 0.
- R3: With in_mode=0, {out_cout,out_f} is the (W+1)-bit sum of two terms and in_cin. By in_sel, the terms are: 0 A, ones; 1 A AND B, ones; 2 A AND NOT B, ones; 3 zero, ones; 4 A, A OR NOT B; 5 A AND B, A OR NOT B; 6 A, NOT B; 7 zero, A OR NOT B; 8 A, A OR B; 9 A, B; 10 A AND NOT B, A OR B; 11 zero, A OR B; 12 A, A; 13 A AND B, A; 14 A AND NOT B, A; 15 zero, A. Here "ones" stands for the all-ones word, which encodes "minus 1".
- R4: in_cin=1 adds exactly one. With in_sel=6 and in_mode=0, the result is A minus B, and out_cout=1 exactly when A >= B unsigned.
- R5: out_aeqb is 1 exactly when out_f is all ones.
- R6: After reset, out_valid is 0 and in_ready is 1.
- R7: A request accepted at a rising edge appears on the outputs with out_valid=1 right after that edge.
- R8: While out_valid=1 and out_ready=0, in_ready is 0, and out_f, out_cout and out_aeqb hold their values.
- R9: If the held beat is taken and no new request is accepted at that edge, out_valid falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request beat present |
| in_ready | output | 1 | Slice can take a request |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_sel | input | 4 | Function code |
| in_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| in_cin | input | 1 | Carry input, adds one when high |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_f | output | W | Result |
| out_cout | output | 1 | Carry-out, bit W of the arithmetic sum |
| out_aeqb | output | 1 | Result is all ones |

## Verification
The bench sweeps every operand pair at width 4, under all thirty-two functions and both carry values. This catches a swapped row in either function map. It also catches a "minus 1" term computed as true subtraction, which gives the right result word but an inverted carry-out. Directed cases on code 6 check the carry at A equal to B and at A below B. A borrow-style carry would flip the carry-out there, and the equality flag would not follow the result word. The bench also stalls the consumer. A slice that kept accepting during the stall would overwrite the held result, and one that failed to drop valid would hand out the same beat twice.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  // First addend of an arithmetic function, chosen by sel[1:0]
  typedef enum logic [1:0] {
    XT_A    = 2'd0,
    XT_AND  = 2'd1,
    XT_ANDN = 2'd2,
    XT_ZERO = 2'd3
  } xterm_e;

  // Second addend of an arithmetic function, chosen by sel[3:2]
  typedef enum logic [1:0] {
    YT_ONES = 2'd0,
    YT_ORN  = 2'd1,
    YT_OR   = 2'd2,
    YT_A    = 2'd3
  } yterm_e;

  localparam int SEL_W = 4;

  // Truth table over index {a,b} for each bitwise function code
  function automatic logic [3:0] logic_table(input logic [SEL_W-1:0] sel);
    logic [3:0] t;
    case (sel)
      4'd0:    t = 4'b0011;
      4'd1:    t = 4'b0111;
      4'd2:    t = 4'b1011;
      4'd3:    t = 4'b1111;
      4'd4:    t = 4'b0001;
      4'd5:    t = 4'b0101;
      4'd6:    t = 4'b1001;
      4'd7:    t = 4'b1101;
      4'd8:    t = 4'b0010;
      4'd9:    t = 4'b0110;
      4'd10:   t = 4'b1010;
      4'd11:   t = 4'b1110;
      4'd12:   t = 4'b0000;
      4'd13:   t = 4'b0100;
      4'd14:   t = 4'b1000;
      default: t = 4'b1100;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/alu16_logic_unit.sv
module alu16_logic_unit
  import alu16_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     f
);

  logic [3:0] tt;

  always_comb tt = logic_table(sel);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb f[i] = tt[{a[i], b[i]}];
  end

endmodule

// File: rtl/alu16_arith_unit.sv
module alu16_arith_unit
  import alu16_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  input  logic             cin,
  output logic [W-1:0]     f,
  output logic             cout
);

  localparam int SW = W + 1;

  xterm_e       xsel;
  yterm_e       ysel;
  logic [W-1:0] xv;
  logic [W-1:0] yv;
  logic [SW-1:0] sum;

  always_comb begin
    xsel = xterm_e'(sel[1:0]);
    ysel = yterm_e'(sel[3:2]);
  end

  always_comb begin
    case (xsel)
      XT_A:    xv = a;
      XT_AND:  xv = a & b;
      XT_ANDN: xv = a & ~b;
      default: xv = '0;
    endcase
  end

  always_comb begin
    case (ysel)
      YT_ONES: yv = '1;
      YT_ORN:  yv = a | ~b;
      YT_OR:   yv = a | b;
      default: yv = a;
    endcase
  end

  always_comb begin
    sum  = {1'b0, xv} + {1'b0, yv} + SW'(cin);
    f    = sum[W-1:0];
    cout = sum[W];
  end

endmodule

// File: rtl/alu16_out_stage.sv
module alu16_out_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_f,
  input  logic         d_cout,
  input  logic         d_aeqb,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_f,
  output logic         out_cout,
  output logic         out_aeqb
);

  logic take;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_f    <= '0;
      out_cout <= 1'b0;
      out_aeqb <= 1'b0;
    end else if (take) begin
      out_f    <= d_f;
      out_cout <= d_cout;
      out_aeqb <= d_aeqb;
    end
  end

endmodule

// File: rtl/alu16_slice.sv
module alu16_slice
  import alu16_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             in_mode,
  input  logic             in_cin,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_f,
  output logic             out_cout,
  output logic             out_aeqb
);

  logic [W-1:0] lf;
  logic [W-1:0] af;
  logic         acout;
  logic [W-1:0] rf;
  logic         rcout;
  logic         raeqb;

  alu16_logic_unit #(.W(W)) u_logic (
    .a   (in_a),
    .b   (in_b),
    .sel (in_sel),
    .f   (lf)
  );

  alu16_arith_unit #(.W(W)) u_arith (
    .a    (in_a),
    .b    (in_b),
    .sel  (in_sel),
    .cin  (in_cin),
    .f    (af),
    .cout (acout)
  );

  always_comb begin
    rf    = in_mode ? lf : af;
    rcout = in_mode ? 1'b0 : acout;
    raeqb = &rf;
  end

  alu16_out_stage #(.W(W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_f       (rf),
    .d_cout    (rcout),
    .d_aeqb    (raeqb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_f     (out_f),
    .out_cout  (out_cout),
    .out_aeqb  (out_aeqb)
  );

endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_f,
  input logic         out_cout,
  input logic         out_aeqb
);

  a_r2_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode) |=> !out_cout);

  a_r5_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_aeqb == (&out_f)));

  a_r6_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_f) && $stable(out_cout) && $stable(out_aeqb)));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind alu16_slice alu16_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_f     (out_f),
  .out_cout  (out_cout),
  .out_aeqb  (out_aeqb)
);

// File: tb/test_alu16_slice.sv
`timescale 1ns/1ps
module test_alu16_slice;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [3:0]   in_sel = '0;
  logic         in_mode = 1'b0;
  logic         in_cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_f;
  logic         out_cout;
  logic         out_aeqb;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu16_slice #(.W(W)) i_alu16_slice (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sel(in_sel), .in_mode(in_mode), .in_cin(in_cin),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_f(out_f), .out_cout(out_cout), .out_aeqb(out_aeqb)
  );

  function automatic logic [W:0] ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [3:0] s, input logic m, input logic c);
    logic [W:0] cw;
    logic [W-1:0] x, y;
    cw = (W+1)'(c);
    if (m) begin
      case (s)
        4'd0:  x = ~a;
        4'd1:  x = ~(a & b);
        4'd2:  x = ~a | b;
        4'd3:  x = ONES;
        4'd4:  x = ~(a | b);
        4'd5:  x = ~b;
        4'd6:  x = ~(a ^ b);
        4'd7:  x = a | ~b;
        4'd8:  x = ~a & b;
        4'd9:  x = a ^ b;
        4'd10: x = b;
        4'd11: x = a | b;
        4'd12: x = '0;
        4'd13: x = a & ~b;
        4'd14: x = a & b;
        default: x = a;
      endcase
      return {1'b0, x};
    end
    case (s)
      4'd0:  begin x = a;      y = ONES;   end
      4'd1:  begin x = a & b;  y = ONES;   end
      4'd2:  begin x = a & ~b; y = ONES;   end
      4'd3:  begin x = '0;     y = ONES;   end
      4'd4:  begin x = a;      y = a | ~b; end
      4'd5:  begin x = a & b;  y = a | ~b; end
      4'd6:  begin x = a;      y = ~b;     end
      4'd7:  begin x = '0;     y = a | ~b; end
      4'd8:  begin x = a;      y = a | b;  end
      4'd9:  begin x = a;      y = b;      end
      4'd10: begin x = a & ~b; y = a | b;  end
      4'd11: begin x = '0;     y = a | b;  end
      4'd12: begin x = a;      y = a;      end
      4'd13: begin x = a & b;  y = a;      end
      4'd14: begin x = a & ~b; y = a;      end
      default: begin x = '0;   y = a;      end
    endcase
    return {1'b0, x} + {1'b0, y} + cw;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Present one request at the current negedge, check at the next negedge
  task automatic run_vec(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] s, input logic m, input logic c);
    logic [W:0] e;
    in_a = a; in_b = b; in_sel = s; in_mode = m; in_cin = c; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e = ref_model(a, b, s, m, c);
    check("R7 out_valid", 32'(out_valid), 32'd1);
    check(m ? "R1 logic result" : "R3 arith result", 32'(out_f), 32'(e[W-1:0]));
    check(m ? "R2 logic carry" : "R3 arith carry", 32'(out_cout), 32'(e[W]));
    check("R5 all-ones flag", 32'(out_aeqb), 32'(&e[W-1:0]));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R6 out_valid at reset", 32'(out_valid), 32'd0);
    check("R6 in_ready at reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 out_valid after reset", 32'(out_valid), 32'd0);
    check("R6 in_ready after reset", 32'(in_ready), 32'd1);

    // Exhaustive sweep: both modes, all codes, both carries, all operands
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              run_vec(W'(a), W'(b), 4'(s), 1'(m), 1'(c));

    // R4 directed: subtraction with carry in
    run_vec(4'd9, 4'd3, 4'd6, 1'b0, 1'b1);
    check("R4 9-3 result", 32'(out_f), 32'd6);
    check("R4 9-3 carry", 32'(out_cout), 32'd1);
    run_vec(4'd3, 4'd9, 4'd6, 1'b0, 1'b1);
    check("R4 3-9 result", 32'(out_f), 32'd10);
    check("R4 3-9 carry", 32'(out_cout), 32'd0);
    run_vec(4'd7, 4'd7, 4'd6, 1'b0, 1'b0);
    check("R5 equal operands flag", 32'(out_aeqb), 32'd1);
    check("R4 equal operands no carry", 32'(out_cout), 32'd0);
    run_vec(4'd5, 4'd6, 4'd9, 1'b0, 1'b1);
    check("R4 5+6+1", 32'(out_f), 32'd12);

    // R2 directed: logic mode carry input has no effect
    run_vec(4'hA, 4'h6, 4'd9, 1'b1, 1'b1);
    check("R2 xor with cin", 32'(out_f), 32'hC);
    check("R2 xor carry", 32'(out_cout), 32'd0);

    // Random mix
    for (int k = 0; k < 400; k++)
      run_vec(W'($urandom), W'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));

    // R8: stall the consumer
    run_vec(4'd4, 4'd2, 4'd9, 1'b0, 1'b0);  // result 6
    out_ready = 1'b0;
    in_a = 4'd1; in_b = 4'd1; in_sel = 4'd9; in_mode = 1'b0; in_cin = 1'b0;
    @(negedge clk);
    check("R8 in_ready low during stall", 32'(in_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 result held", 32'(out_f), 32'd6);
    check("R8 valid held", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 pending request taken", 32'(out_f), 32'd2);
    check("R7 valid after release", 32'(out_valid), 32'd1);

    // R9: drain without new request
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 out_valid dropped", 32'(out_valid), 32'd0);
    check("R9 in_ready when empty", 32'(in_ready), 32'd1);

    done = 1'b1;
    finish_run();
  end

endmodule